// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

The block is an eight-pin general-purpose I/O port controlled through a small register interface. A direction register chooses, pin by pin, whether that pin drives the value held in the output latch or leaves its driver off so it can be read as an input. The output latch can be read back on its own address. A read of that address returns the stored value and not the pin level, so software can change one bit with a read-modify-write and the other bits keep their values.

A control register holds one active-low bit that switches on the weak pull-ups for the whole port. A pull-up is applied only to a pin that is currently an input. The same register also holds the analog-select mask for the analog-capable pins. A pin in analog mode reads as zero on the digital read path. Pin inputs pass through a two-flop synchronizer before any read sees them.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, the output latch reads 8'h00 and the control register reads 8'h9F. In the control register, bit 7 is the pull-up disable bit, which resets to 1, and bits 4:0 are the analog selects, which reset to all ones. With those values pad_oe and pull_en are both 8'h00.
- R2: A direction bit of 0 sets that pin's pad_oe to 1 and puts the latch bit on pad_out. A direction bit of 1 clears pad_oe for that pin. The direction register is at address 2, and a write takes effect on the next clock edge.
- R3: A write to address 0 (port) or to address 1 (latch) loads the output latch. A read of address 1 returns the latch contents whatever the pin levels are.
- R4: A read of address 0 returns the synchronized pin levels with every analog-selected pin forced to 0.
- R5: pull_en for a pin is 1 exactly when control bit 7 is 0 and that pin's direction bit is 1. A write of 1 to bit 7 turns off all pull-ups on the next edge.
- R6: The control register is at address 3. Only bits 7 and 4:0 can be written. Bits 6:5 read as 0 and writes to them are ignored.
- R7: A change on pad_in appears on a port read after exactly two rising clock edges. After one edge the read still shows the old value.
- R8: While wr_en is low, no register changes, whatever addr and wr_data carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 control |
| wr_en | input | 1 | Write strobe; writes happen at the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the selected address |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Value driven on pins whose pad_oe is set |
| pad_oe | output | 8 | Output enable per pin; 1 drives the pin |
| pull_en | output | 8 | Weak pull-up enable per pin |

## Verification
The assertions check several relations on every cycle. Each write reaches pad_out or pad_oe on the following edge. Nothing changes while no write is strobed. No pin has its pull-up and its driver on at once. Once two edges have passed since reset, every port read equals the pin levels from two edges earlier with the analog pins masked.

Some properties can only be shown by the bench's scenarios. These are the exact reset values, the latch read-back while the pins differ from the latch, the masking of the reserved control bits, and the one-edge point at which a pin change is not yet visible.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_PORT  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_CTRL  = 2'd3
  } gpio_addr_e;

  localparam int unsigned GPIO_W = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned     WIDTH      = 8,
  parameter logic [WIDTH-1:0] ANALOG_CAP = 8'h1F,
  parameter logic [WIDTH-1:0] ANALOG_RST = 8'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] analog_q,
  output logic             pu_n_q,
  output logic             lat_we,
  output logic             dir_we,
  output logic             ctrl_we,
  output logic [WIDTH-1:0] rd_data
);
  localparam int unsigned PU_BIT = WIDTH - 1;

  function automatic logic [WIDTH-1:0] digital_view(input logic [WIDTH-1:0] pins,
                                                    input logic [WIDTH-1:0] ana);
    return pins & ~ana;
  endfunction

  function automatic logic [WIDTH-1:0] ctrl_view(input logic pu_n,
                                                 input logic [WIDTH-1:0] ana);
    logic [WIDTH-1:0] v;
    v = ana & ANALOG_CAP;
    v[PU_BIT] = pu_n;
    return v;
  endfunction

  gpio_addr_e sel;
  assign sel     = gpio_addr_e'(addr);
  assign lat_we  = wr_en && (sel == REG_PORT || sel == REG_LATCH);
  assign dir_we  = wr_en && (sel == REG_DIR);
  assign ctrl_we = wr_en && (sel == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '0;
      dir_q    <= '1;
      analog_q <= ANALOG_RST & ANALOG_CAP;
      pu_n_q   <= 1'b1;
    end else begin
      if (lat_we) lat_q <= wr_data;
      if (dir_we) dir_q <= wr_data;
      if (ctrl_we) begin
        analog_q <= wr_data & ANALOG_CAP;
        pu_n_q   <= wr_data[PU_BIT];
      end
    end
  end

  always_comb begin
    unique case (sel)
      REG_PORT:  rd_data = digital_view(pin_sync, analog_q);
      REG_LATCH: rd_data = lat_q;
      REG_DIR:   rd_data = dir_q;
      default:   rd_data = ctrl_view(pu_n_q, analog_q);
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic             pu_n_q,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pull_en
);
  function automatic logic [WIDTH-1:0] pull_mask(input logic pu_n,
                                                 input logic [WIDTH-1:0] dir);
    return pu_n ? '0 : dir;
  endfunction

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;
  assign pull_en = pull_mask(pu_n_q, dir_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH      = GPIO_W,
  parameter logic [WIDTH-1:0] ANALOG_CAP = 8'h1F,
  parameter logic [WIDTH-1:0] ANALOG_RST = 8'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pull_en
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] lat_q, dir_q, analog_sel;
  logic             pu_n_q;
  logic             lat_we, dir_we, ctrl_we;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ANALOG_CAP(ANALOG_CAP), .ANALOG_RST(ANALOG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .pin_sync(pin_sync), .lat_q(lat_q), .dir_q(dir_q), .analog_q(analog_sel),
    .pu_n_q(pu_n_q), .lat_we(lat_we), .dir_we(dir_we), .ctrl_we(ctrl_we),
    .rd_data(rd_data)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .lat_q(lat_q), .dir_q(dir_q), .pu_n_q(pu_n_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pull_en,
  input logic [WIDTH-1:0] analog_sel
);
  logic [1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  // R2
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIR) |=> (pad_oe == ~$past(wr_data)));

  // R3
  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == REG_PORT || addr == REG_LATCH)) |=> (pad_out == $past(wr_data)));

  // R5
  a_r5_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_en & pad_oe) == '0));

  // R5
  a_r5_pull_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_CTRL && wr_data[WIDTH-1]) |=> (pull_en == '0));

  // R4 and R7
  a_r7_port_read: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= 2'd2 && addr == REG_PORT) |-> (rd_data == ($past(pad_in, 2) & ~analog_sel)));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pull_en)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pull_en(pull_en), .analog_sel(analog_sel)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, pad_in, pad_out, pad_oe, pull_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_en(pull_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic settle_pins(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    read_reg(2'd1, v); check("R1 latch", v, 8'h00);
    read_reg(2'd2, v); check("R1 dir", v, 8'hFF);
    read_reg(2'd3, v); check("R1 ctrl", v, 8'h9F);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pull_en", pull_en, 8'h00);
    settle_pins(8'hFF);
    read_reg(2'd0, v); check("R4 analog pins read zero", v, 8'hE0);
  endtask

  task automatic test_direction();
    logic [7:0] v;
    write_reg(2'd2, 8'h30);
    write_reg(2'd0, 8'hA5);
    check("R2 pad_oe", pad_oe, 8'hCF);
    check("R3 pad_out via port addr", pad_out, 8'hA5);
    read_reg(2'd2, v); check("R2 dir readback", v, 8'h30);
  endtask

  task automatic test_latch_readback();
    logic [7:0] v;
    write_reg(2'd3, 8'h80);
    write_reg(2'd1, 8'h5A);
    settle_pins(8'h0F);
    read_reg(2'd1, v); check("R3 latch read not pins", v, 8'h5A);
    read_reg(2'd0, v); check("R4 port read pins", v, 8'h0F);
    check("R3 pad_out via latch addr", pad_out, 8'h5A);
  endtask

  task automatic test_pullups();
    write_reg(2'd3, 8'h00);
    write_reg(2'd2, 8'h30);
    check("R5 pull on inputs only", pull_en, 8'h30);
    write_reg(2'd2, 8'hF0);
    check("R5 pull follows dir", pull_en, 8'hF0);
    write_reg(2'd3, 8'h80);
    check("R5 global disable", pull_en, 8'h00);
  endtask

  task automatic test_analog_ctrl();
    logic [7:0] v;
    write_reg(2'd3, 8'h03);
    settle_pins(8'hFF);
    read_reg(2'd0, v); check("R4 partial analog mask", v, 8'hFC);
    write_reg(2'd3, 8'h7F);
    read_reg(2'd3, v); check("R6 reserved bits ignored", v, 8'h1F);
    read_reg(2'd0, v); check("R6 analog mask from ctrl", v, 8'hE0);
  endtask

  task automatic test_sync();
    logic [7:0] v;
    write_reg(2'd3, 8'h80);
    settle_pins(8'h00);
    @(negedge clk);
    pad_in = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    read_reg(2'd0, v); check("R7 one edge still old", v, 8'h00);
    @(posedge clk);
    @(negedge clk);
    read_reg(2'd0, v); check("R7 two edges new", v, 8'h3C);
  endtask

  task automatic test_no_write();
    logic [7:0] v, oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd2; wr_data = 8'h00;
    repeat (2) @(posedge clk);
    addr = 2'd1; wr_data = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 pad_oe held", pad_oe, oe0);
    check("R8 pad_out held", pad_out, out0);
    read_reg(2'd2, v); check("R8 dir held", v, ~oe0);
    read_reg(2'd1, v); check("R8 latch held", v, out0);
  endtask

  initial begin
    pad_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_direction();
    test_latch_readback();
    test_pullups();
    test_analog_ctrl();
    test_sync();
    test_no_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule